// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

The block takes one asynchronous serial line and turns each frame on it into a parallel byte. An outside divider supplies a sample enable at sixteen times the bit rate. The line passes through a synchronizer. Sample counts are then taken only in cycles where the enable is high. A four-state controller runs the frame: it waits in idle, qualifies a start bit, shifts in the data bits least significant first, checks the stop bit, and locks into an error state if framing fails.

A downstream loader watches the ready flag. The flag is high for as long as the controller sits in its stop state. During that time the received byte is held steady at the output. In this framing the stop bit is expected low, the same level as the start bit. After a good stop check, the receiver goes back to idle only once the line has returned high. If the line is high when the stop check is made, the receiver enters a sticky error state that only reset clears.

Top module: `serial_byte_rx`

## Requirements
- R1: After an active-low reset, `rx_byte` is 0x00 and both `byte_rdy` and `frame_err` are 0.
- R2: A start bit is accepted only after the synchronized line has been low on 8 consecutive enabled samples. If the line goes high before the 8th, the low count restarts and the receiver stays idle.
- R3: Once the start is accepted, each data bit is taken on the 16th enabled sample of its bit period. The 8 bits are shifted in least significant bit first and appear on `rx_byte`.
- R4: `byte_rdy` rises when the 8th data bit is captured. While it is high, `rx_byte` does not change.
- R5: If the line is high on the 16th enabled sample of the stop period, `frame_err` goes high and `byte_rdy` goes low. `frame_err` then stays high, and later frames are ignored until reset.
- R6: If the line is low on the 16th stop sample, `byte_rdy` stays high while the line remains low. It drops on the first enabled sample that sees the line high, and the receiver then returns to idle.
- R7: In a cycle where `smp_en` is low, `rx_byte`, `byte_rdy` and `frame_err` keep their values.
- R8: The serial input passes through a two-flop synchronizer before the controller uses it. Receive results are the same for any spacing of sample enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_en | input | 1 | Sample enable, one pulse per sample at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_byte | output | 8 | Received data byte |
| byte_rdy | output | 1 | Byte ready for the downstream loader (high in stop state) |
| frame_err | output | 1 | Sticky framing error |

## Verification
Three corner cases get directed tests.

- **Start aborted after seven samples.** A low pulse seven samples long is followed by a real frame. A receiver that failed to clear its start count would begin the next frame early and return a shifted byte.
- **Line held low after the stop check, and a stalled sample enable.** The stop level is held past the check and the sample enable is stopped while the line goes high. A receiver that returned to idle too soon, or that ran without the enable, would drop the ready flag early.
- **Framing error.** A bad stop bit is followed by a good frame and then by reset. A receiver whose error state was not sticky would report the second byte.

Table-driven frames at several enable spacings show whether bit order and the 16th-sample capture point are right.

// File: rtl/rx_pkg.sv
package rx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BITS = 2'd1,
      ST_STOP = 2'd2,
      ST_FAIL = 2'd3
   } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= IDLE_LVL;
               else        chain[0] <= din;
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= IDLE_LVL;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_tick_counter.sv
module rx_tick_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (inc) count <= count + 1'b1;
   end
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
   parameter int DW        = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_en,
   input  logic          bit_in,
   output logic [DW-1:0] data,
   output logic          last_bit
);
   localparam int IW = (DW > 1) ? $clog2(DW) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(DW - 1);

   logic [IW-1:0] idx;
   logic [DW-1:0] data_nxt;

   generate
      if (DW == 1) begin : g_single
         assign data_nxt = bit_in;
      end else if (LSB_FIRST) begin : g_lsb
         assign data_nxt = {bit_in, data[DW-1:1]};
      end else begin : g_msb
         assign data_nxt = {data[DW-2:0], bit_in};
      end
   endgenerate

   assign last_bit = (idx == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
         idx  <= '0;
      end else if (shift_en) begin
         data <= data_nxt;
         idx  <= last_bit ? '0 : idx + 1'b1;
      end
   end
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
   parameter int DATA_BITS   = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int START_CHECK = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_en,
   input  logic                 rx_line,
   output logic [DATA_BITS-1:0] rx_byte,
   output logic                 byte_rdy,
   output logic                 frame_err
);
   import rx_pkg::*;

   localparam int CW = $clog2(OVERSAMPLE);
   localparam logic [CW-1:0] OS_LAST    = CW'(OVERSAMPLE - 1);
   localparam logic [CW-1:0] START_LAST = CW'(START_CHECK - 1);

   generate
      if (OVERSAMPLE < 2) begin : g_bad_os
         $error("OVERSAMPLE must be at least 2");
      end
      if (START_CHECK < 1 || START_CHECK > OVERSAMPLE) begin : g_bad_start
         $error("START_CHECK must lie in 1..OVERSAMPLE");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DATA_BITS < 1) begin : g_bad_dw
         $error("DATA_BITS must be at least 1");
      end
   endgenerate

   rx_state_e     st, st_nxt;
   logic          line_s;
   logic [CW-1:0] cnt;
   logic          cnt_clr, cnt_inc;
   logic          shift_en, last_bit;
   logic          stop_ok, stop_ok_set, stop_ok_clr;

   rx_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .din (rx_line),
      .dout (line_s)
   );

   rx_tick_counter #(.W(CW)) u_cnt (
      .clk (clk),
      .rst_n (rst_n),
      .clr (cnt_clr),
      .inc (cnt_inc),
      .count (cnt)
   );

   rx_shifter #(.DW(DATA_BITS), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk (clk),
      .rst_n (rst_n),
      .shift_en (shift_en),
      .bit_in (line_s),
      .data (rx_byte),
      .last_bit (last_bit)
   );

   always_comb begin
      st_nxt      = st;
      cnt_clr     = 1'b0;
      cnt_inc     = 1'b0;
      shift_en    = 1'b0;
      stop_ok_set = 1'b0;
      stop_ok_clr = 1'b0;
      if (smp_en) begin
         unique case (st)
            ST_IDLE: begin
               if (line_s) begin
                  cnt_clr = 1'b1;
               end else if (cnt == START_LAST) begin
                  cnt_clr = 1'b1;
                  st_nxt  = ST_BITS;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            ST_BITS: begin
               if (cnt == OS_LAST) begin
                  cnt_clr  = 1'b1;
                  shift_en = 1'b1;
                  if (last_bit) st_nxt = ST_STOP;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            ST_STOP: begin
               if (stop_ok) begin
                  if (line_s) begin
                     stop_ok_clr = 1'b1;
                     cnt_clr     = 1'b1;
                     st_nxt      = ST_IDLE;
                  end
               end else if (cnt == OS_LAST) begin
                  cnt_clr = 1'b1;
                  if (line_s) st_nxt = ST_FAIL;
                  else        stop_ok_set = 1'b1;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         stop_ok <= 1'b0;
      end else begin
         st <= st_nxt;
         if (stop_ok_clr)      stop_ok <= 1'b0;
         else if (stop_ok_set) stop_ok <= 1'b1;
      end
   end

   assign byte_rdy  = (st == ST_STOP);
   assign frame_err = (st == ST_FAIL);
endmodule

// File: rtl/serial_byte_rx_chk.sv
module serial_byte_rx_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_en,
   input logic          line_s,
   input logic [DW-1:0] rx_byte,
   input logic          byte_rdy,
   input logic          frame_err
);
   // R5
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);

   // R5
   rdy_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_rdy && frame_err));

   // R7
   hold_no_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en |=> ($stable(byte_rdy) && $stable(frame_err) && $stable(rx_byte)));

   // R4
   byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_rdy ##1 byte_rdy |-> $stable(rx_byte));

   // R6
   idle_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(byte_rdy) && !frame_err) |-> ($past(line_s) && $past(smp_en)));
endmodule

bind serial_byte_rx serial_byte_rx_chk #(.DW(DATA_BITS)) u_chk (
   .clk (clk),
   .rst_n (rst_n),
   .smp_en (smp_en),
   .line_s (line_s),
   .rx_byte (rx_byte),
   .byte_rdy (byte_rdy),
   .frame_err (frame_err)
);

// File: tb/serial_byte_rx_tb.sv
module serial_byte_rx_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       smp_en = 1'b0;
   logic       rx_line = 1'b1;
   logic [7:0] rx_byte;
   logic       byte_rdy, frame_err;
   int         total = 0, failed = 0;

   always #4 clk = ~clk;

   serial_byte_rx u_dut (
      .clk (clk), .rst_n (rst_n), .smp_en (smp_en), .rx_line (rx_line),
      .rx_byte (rx_byte), .byte_rdy (byte_rdy), .frame_err (frame_err)
   );

   // {data byte, enable spacing}
   localparam int NV = 6;
   localparam logic [11:0] VEC [NV] = '{
      {8'h55, 4'd1}, {8'hA3, 4'd1}, {8'h00, 4'd1},
      {8'hFF, 4'd2}, {8'h81, 4'd3}, {8'h3C, 4'd2}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - failed, total);
   endtask

   // one sample unit: line level held for div clocks, enable on the first
   task automatic unit(input logic val, input int div);
      for (int k = 0; k < div; k++) begin
         @(negedge clk);
         rx_line = val;
         smp_en  = (k == 0);
      end
   endtask

   task automatic units(input logic val, input int n, input int div);
      for (int j = 0; j < n; j++) unit(val, div);
   endtask

   task automatic idle(input int n);
      for (int j = 0; j < n; j++) begin
         @(negedge clk);
         smp_en = 1'b0;
      end
   endtask

   task automatic send_frame(input logic [7:0] b, input logic stop_lvl, input int div);
      units(1'b0, 8, div);
      for (int i = 0; i < 8; i++) units(b[i], 16, div);
      units(stop_lvl, 16, div);
      units(stop_lvl, 4, div);
      idle(1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; smp_en = 1'b0; rx_line = 1'b1;
      idle(3);
      rst_n = 1'b1;
      idle(1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failed++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      idle(3);
      // R1 reset values
      chk("R1 rx_byte", rx_byte, 8'h00);
      chk("R1 byte_rdy", byte_rdy, 0);
      chk("R1 frame_err", frame_err, 0);
      rst_n = 1'b1;
      units(1'b1, 10, 1);

      // R3 R4 R6 R8 table of frames at several enable spacings
      for (int v = 0; v < NV; v++) begin
         send_frame(VEC[v][11:4], 1'b0, int'(VEC[v][3:0]));
         chk("R3 byte value", rx_byte, VEC[v][11:4]);
         chk("R4 ready after stop", byte_rdy, 1);
         units(1'b1, 4, int'(VEC[v][3:0]));
         idle(1);
         chk("R6 ready dropped on high", byte_rdy, 0);
      end

      // R2 start aborted after 7 low samples, then a real frame
      units(1'b0, 7, 1);
      units(1'b1, 10, 1);
      idle(1);
      chk("R2 no ready after short low", byte_rdy, 0);
      chk("R2 no error after short low", frame_err, 0);
      send_frame(8'hC5, 1'b0, 1);
      chk("R2 aligned after abort", rx_byte, 8'hC5);

      // R6 line held low keeps ready
      units(1'b0, 30, 1);
      idle(1);
      chk("R6 ready while line low", byte_rdy, 1);

      // R7 enable held low freezes outputs
      @(negedge clk);
      rx_line = 1'b1; smp_en = 1'b0;
      idle(12);
      chk("R7 ready frozen", byte_rdy, 1);
      chk("R7 byte frozen", rx_byte, 8'hC5);
      units(1'b1, 4, 1);
      idle(1);
      chk("R6 ready cleared after enable", byte_rdy, 0);

      // R5 bad stop bit
      send_frame(8'h6E, 1'b1, 1);
      chk("R5 error set", frame_err, 1);
      chk("R5 no ready on error", byte_rdy, 0);
      send_frame(8'h12, 1'b0, 1);
      chk("R5 error sticky", frame_err, 1);
      chk("R5 later frame ignored", byte_rdy, 0);
      do_reset();
      chk("R1 error cleared by reset", frame_err, 0);
      chk("R1 byte cleared by reset", rx_byte, 8'h00);
      units(1'b1, 4, 1);
      send_frame(8'h9A, 1'b0, 2);
      chk("R3 frame after reset", rx_byte, 8'h9A);

      summary();
      $finish;
   end
endmodule